// File: doc/BRIEF.md
# XGMII Fixed-Word Payload Checker

The block watches a 32-bit XGMII-style receive stream, one column per clock: four byte lanes, each with a control flag. It finds where each packet begins and ends. Every payload column inside a packet is compared against a programmed 32-bit word, together with a programmed 4-bit pattern of control flags. Two counters record the results: one counts mismatching payload columns and the other counts completed packets.

Software sets up the expected word and flags through a small register port. It then writes 0x0003 to the mode register and lets a burst run. Afterwards it reads both counters, and each read clears the counter it returns. A clean loopback leaves the mismatch count at zero. A corrupted payload gives a non-zero mismatch count, while the packet count still equals the burst length.

Top module: `xgmii_pattern_checker`

## Requirements
- R1: After reset, registers 0 to 3, the mismatch count and the packet count all read zero.
- R2: Register 0 is the mode register. Register 1 holds expected data bits 15:0 and register 2 holds bits 31:16. Register 3 bits 3:0 hold the expected control flags, where bit i belongs to byte lane i at data bits 8i+7:8i. Each of these registers reads back the full 16-bit value last written to it.
- R3: Comparison and counting take place only while mode register bits 1:0 both equal 1, for example after writing 0x0003. With any other value, stream activity leaves both counters unchanged.
- R4: A start column has control flag 0 set and byte 0xFB in lane 0. A terminate column has some lane whose flag is set and whose byte is 0xFD. Only columns strictly between a start and a terminate are compared, so idle columns never add mismatches.
- R5: A compared column whose 32 data bits differ from the expected word, or whose 4 flags differ from the expected flags, adds exactly one to the mismatch count.
- R6: Each terminate column that follows a start adds one to the packet count, whether or not the payload matched. A terminate column with no start before it adds nothing.
- R7: Both counters are CNT_W bits wide. On reaching 2^CNT_W-1 they stay at that value and do not wrap.
- R8: A read strobe to address 4 returns the mismatch count, and one to address 5 returns the packet count. The value appears on reg_rdata in the cycle after the strobe, and the counter clears at that same edge. If an increment lands on the edge of the read, the counter holds 1 afterwards.
- R9: A burst whose payload equals the expected word and flags leaves the mismatch count at zero, and the packet count equals the number of packets sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 32 | Column data, lane 0 in bits 7:0 |
| rx_ctl | input | 4 | Per-lane control flags |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the cycle after reg_rd |

## Verification
The hardest case to reach is a counter read that lands on the same clock edge as a mismatch increment. Only then do the clear and the increment compete. The bench drives a mismatching payload column and the read strobe in the same cycle, partway through a packet. It then checks both the value returned and the count that remains. Saturation is reached by shrinking the counters to 5 bits and sending one long corrupted packet. A sweep over burst length, packet length and match/mismatch covers the main counting paths.

// File: rtl/xpc_pkg.sv
package xpc_pkg;
    localparam int LANES = 4;
    localparam int COL_W = 8 * LANES;
    localparam logic [7:0] CH_START = 8'hFB;
    localparam logic [7:0] CH_TERM  = 8'hFD;

    typedef enum logic [2:0] {
        A_MODE    = 3'd0,
        A_EXP_LO  = 3'd1,
        A_EXP_HI  = 3'd2,
        A_EXP_CTL = 3'd3,
        A_ERR_CNT = 3'd4,
        A_PKT_CNT = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [COL_W-1:0] data;
        logic [LANES-1:0] ctl;
    } column_t;

    typedef enum logic {FR_IDLE, FR_BODY} frame_state_e;

    function automatic logic is_start(column_t c);
        return c.ctl[0] && (c.data[7:0] == CH_START);
    endfunction

    function automatic logic is_term(column_t c);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < LANES; i++)
            if (c.ctl[i] && (c.data[8*i +: 8] == CH_TERM)) hit = 1'b1;
        return hit;
    endfunction
endpackage

// File: rtl/xpc_regs.sv
module xpc_regs
    import xpc_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             rd,
    input  logic [2:0]       addr,
    input  logic [REG_W-1:0] wdata,
    input  logic [CNT_W-1:0] err_cnt,
    input  logic [CNT_W-1:0] pkt_cnt,
    output logic [REG_W-1:0] rdata,
    output logic [1:0]       mode,
    output logic [COL_W-1:0] exp_data,
    output logic [LANES-1:0] exp_ctl,
    output logic             err_clr,
    output logic             pkt_clr
);
    logic [REG_W-1:0] mode_q, lo_q, hi_q, ctl_q;
    logic [REG_W-1:0] rd_mux;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            ctl_q  <= '0;
        end else if (wr) begin
            case (reg_addr_e'(addr))
                A_MODE:    mode_q <= wdata;
                A_EXP_LO:  lo_q   <= wdata;
                A_EXP_HI:  hi_q   <= wdata;
                A_EXP_CTL: ctl_q  <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            A_MODE:    rd_mux = mode_q;
            A_EXP_LO:  rd_mux = lo_q;
            A_EXP_HI:  rd_mux = hi_q;
            A_EXP_CTL: rd_mux = ctl_q;
            A_ERR_CNT: rd_mux = REG_W'(err_cnt);
            A_PKT_CNT: rd_mux = REG_W'(pkt_cnt);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= rd_mux;
    end

    assign mode     = mode_q[1:0];
    assign exp_data = {hi_q, lo_q};
    assign exp_ctl  = ctl_q[LANES-1:0];
    assign err_clr  = rd && (addr == A_ERR_CNT);
    assign pkt_clr  = rd && (addr == A_PKT_CNT);
endmodule

// File: rtl/xpc_frame.sv
module xpc_frame
    import xpc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  column_t col,
    output logic    payload_col,
    output logic    pkt_done
);
    frame_state_e state_q, state_d;
    logic sof, eof;

    assign sof = is_start(col);
    assign eof = is_term(col);

    always_comb begin
        state_d     = state_q;
        payload_col = 1'b0;
        pkt_done    = 1'b0;
        if (!active) begin
            state_d = FR_IDLE;
        end else begin
            case (state_q)
                FR_IDLE: if (sof) state_d = FR_BODY;
                FR_BODY: begin
                    if (eof) begin
                        state_d  = FR_IDLE;
                        pkt_done = 1'b1;
                    end else if (!sof) begin
                        payload_col = 1'b1;
                    end
                end
                default: state_d = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= FR_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/xpc_counter.sv
module xpc_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (clr)
            cnt <= inc ? CNT_W'(1) : '0;
        else if (inc && cnt != TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/xgmii_pattern_checker.sv
module xgmii_pattern_checker
    import xpc_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      rx_data,
    input  logic [3:0]       rx_ctl,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);
    column_t          col;
    logic [1:0]       mode;
    logic [COL_W-1:0] exp_data;
    logic [LANES-1:0] exp_ctl;
    logic             active, payload_col, pkt_done;
    logic             err_inc, pkt_inc, err_clr, pkt_clr;
    logic [CNT_W-1:0] err_cnt, pkt_cnt;

    assign col    = '{data: rx_data, ctl: rx_ctl};
    assign active = (mode == 2'b11);

    xpc_regs #(.REG_W(REG_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
        .wdata(reg_wdata), .err_cnt(err_cnt), .pkt_cnt(pkt_cnt),
        .rdata(reg_rdata), .mode(mode), .exp_data(exp_data),
        .exp_ctl(exp_ctl), .err_clr(err_clr), .pkt_clr(pkt_clr)
    );

    xpc_frame u_frame (
        .clk(clk), .rst(rst), .active(active), .col(col),
        .payload_col(payload_col), .pkt_done(pkt_done)
    );

    assign err_inc = payload_col && ((col.data != exp_data) || (col.ctl != exp_ctl));
    assign pkt_inc = pkt_done;

    xpc_counter #(.CNT_W(CNT_W)) u_err (
        .clk(clk), .rst(rst), .inc(err_inc), .clr(err_clr), .cnt(err_cnt)
    );

    xpc_counter #(.CNT_W(CNT_W)) u_pkt (
        .clk(clk), .rst(rst), .inc(pkt_inc), .clr(pkt_clr), .cnt(pkt_cnt)
    );
endmodule

// File: rtl/xpc_sva.sv
module xpc_sva #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             active,
    input logic             err_inc,
    input logic             pkt_inc,
    input logic             err_clr,
    input logic             pkt_clr,
    input logic [CNT_W-1:0] err_cnt,
    input logic [CNT_W-1:0] pkt_cnt
);
    localparam logic [CNT_W-1:0] TOP = '1;

    assert_step_one_R5: assert property (@(posedge clk) disable iff (rst)
        !err_clr |=> (err_cnt == $past(err_cnt)) || (err_cnt == $past(err_cnt) + 1'b1));

    assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!active && !err_clr && !pkt_clr) |=> ($stable(err_cnt) && $stable(pkt_cnt)));

    assert_pkt_only_on_term_R6: assert property (@(posedge clk) disable iff (rst)
        (!pkt_inc && !pkt_clr) |=> $stable(pkt_cnt));

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (!err_clr && err_cnt == TOP) |=> err_cnt == TOP);

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (err_clr && !err_inc) |=> err_cnt == '0);
endmodule

bind xgmii_pattern_checker xpc_sva #(.CNT_W(CNT_W)) u_sva (
    .clk(clk), .rst(rst), .active(active), .err_inc(err_inc),
    .pkt_inc(pkt_inc), .err_clr(err_clr), .pkt_clr(pkt_clr),
    .err_cnt(err_cnt), .pkt_cnt(pkt_cnt)
);

// File: tb/sim_xgmii_pattern_checker.sv
module sim_xgmii_pattern_checker;
    localparam int CNT_W = 5;
    localparam int CMAX  = (1 << CNT_W) - 1;
    localparam logic [31:0] EXPW = 32'hA5C3_1E69;
    localparam logic [31:0] IDLE_D = 32'h0707_0707;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] rx_data = IDLE_D;
    logic [3:0]  rx_ctl = 4'hF;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;

    int n_chk = 0, n_bad = 0;
    logic [15:0] v;

    always #4 clk = ~clk;

    xgmii_pattern_checker #(.REG_W(16), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_ctl(rx_ctl),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        reg_rd = 1'b1; reg_addr = a;
        tick();
        d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic col(logic [31:0] d, logic [3:0] c);
        rx_data = d; rx_ctl = c;
        tick();
        rx_data = IDLE_D; rx_ctl = 4'hF;
    endtask

    task automatic idles(int n);
        for (int i = 0; i < n; i++) col(IDLE_D, 4'hF);
    endtask

    task automatic sop();
        col(32'h5555_55FB, 4'b0001);
    endtask

    task automatic eop();
        col(32'h0707_07FD, 4'hF);
    endtask

    task automatic packet(int len, logic [31:0] d, logic [3:0] c);
        sop();
        for (int i = 0; i < len; i++) col(d, c);
        eop();
        idles(2);
    endtask

    task automatic set_exp(logic [31:0] d, logic [3:0] c);
        wr(3'd1, d[15:0]);
        wr(3'd2, d[31:16]);
        wr(3'd3, {12'h0, c});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            check("R1 reset", v, 16'h0);
        end

        // R2 register readback
        wr(3'd0, 16'hBEE2); rd(3'd0, v); check("R2 mode", v, 16'hBEE2);
        set_exp(32'h1234_9ABC, 4'hB);
        rd(3'd1, v); check("R2 lo", v, 16'h9ABC);
        rd(3'd2, v); check("R2 hi", v, 16'h1234);
        rd(3'd3, v); check("R2 ctl", v, 16'h000B);

        // R5 R6 R9 sweep: burst x length x match/mismatch
        set_exp(EXPW, 4'h0);
        wr(3'd0, 16'h0003);
        for (int b = 1; b <= 3; b++)
            for (int l = 1; l <= 4; l++)
                for (int m = 0; m < 2; m++) begin
                    for (int p = 0; p < b; p++)
                        packet(l, (m == 1) ? ~EXPW : EXPW, 4'h0);
                    rd(3'd4, v); check("R5/R9 mismatches", v, 16'((m == 1) ? b * l : 0));
                    rd(3'd5, v); check("R6 packets", v, 16'(b));
                    rd(3'd4, v); check("R8 cleared", v, 16'h0);
                end

        // R5 flag mismatch only
        set_exp(EXPW, 4'b1000);
        packet(3, EXPW, 4'b0000);
        packet(2, EXPW, 4'b1000);
        rd(3'd4, v); check("R5 flag mismatch", v, 16'd3);
        rd(3'd5, v); check("R6 packets", v, 16'd2);
        set_exp(EXPW, 4'h0);

        // R4 idle and out-of-packet columns, stray terminate
        idles(5);
        col(~EXPW, 4'h0);
        eop();
        col(~EXPW, 4'h0);
        rd(3'd4, v); check("R4 outside packet", v, 16'd0);
        rd(3'd5, v); check("R6 stray terminate", v, 16'd0);

        // R3 disabled holds counters
        packet(2, ~EXPW, 4'h0);
        wr(3'd0, 16'h0001);
        packet(3, ~EXPW, 4'h0);
        wr(3'd0, 16'h0002);
        packet(3, ~EXPW, 4'h0);
        wr(3'd0, 16'h0000);
        packet(3, ~EXPW, 4'h0);
        rd(3'd4, v); check("R3 hold mismatches", v, 16'd2);
        rd(3'd5, v); check("R3 hold packets", v, 16'd1);
        wr(3'd0, 16'h0003);

        // R7 saturation
        packet(40, ~EXPW, 4'h0);
        rd(3'd4, v); check("R7 saturate", v, 16'(CMAX));
        rd(3'd5, v); check("R7 packets", v, 16'd1);

        // R8 read coinciding with an increment
        sop();
        col(~EXPW, 4'h0);
        col(~EXPW, 4'h0);
        rx_data = ~EXPW; rx_ctl = 4'h0; reg_rd = 1'b1; reg_addr = 3'd4;
        tick();
        v = reg_rdata;
        reg_rd = 1'b0; rx_data = IDLE_D; rx_ctl = 4'hF;
        check("R8 read value", v, 16'd2);
        col(~EXPW, 4'h0);
        eop();
        idles(2);
        rd(3'd4, v); check("R8 increment kept", v, 16'd2);
        rd(3'd5, v); check("R8 packets", v, 16'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule